// File: doc/BRIEF.md
# Memory Controller Status and Configuration Registers

This block is the software-visible status file of a memory controller. It keeps three 32-bit words: one that captures ECC error events, one that holds control settings, and one that describes the installed memory. Software reaches them through a simple request port. Each request carries a word offset, a write flag and write data. Exactly one clock after a request is accepted, the block returns a response with a valid flag, an error flag and read data.

The memory datapath reports errors on a sideband strobe. Each report says whether the error was corrected or uncorrectable and carries the syndrome and the failing page. Software acknowledges a reported error by writing ones to the flag bits it wants cleared.

The configuration word is fixed at reset. It is built from an elaboration-time installed size. Up to 2 MB the memory is modelled as 128 KB boards. Above 2 MB it is modelled as 512 KB boards that sit only in even slots.

Top module: `memctl_csr_file`

## Requirements
- R1: Offset 0 selects the error word, offset 1 the control word and offset 2 the configuration word. A read or write at any other offset returns rsp_error=1 with rsp_rdata=0 and changes no state.
- R2: Every accepted request (acc_valid=1) produces exactly one response cycle (rsp_valid=1) on the next clock. With no request, rsp_valid stays 0. Read data reflects the state before that request's clock edge.
- R3: After reset the error word and the control word read 0. The configuration word reads with its restart flag (bit 16) at 1 and its start address (bits 23:17) at 0.
- R4: Writing the error word clears each of bit 29 (corrected data), bit 30 (substitute high) and bit 31 (substitute) that is written as 1. All other bits of the error word are unchanged by the write.
- R5: A control write stores the written value masked to bits 6:0 (check syndrome), 25 (ECC off), 26 (diagnostic), 27 (page mode) and 28 (corrected-report enable). Every other bit reads 0, including the page-address field at bits 23:9.
- R6: Writes to the configuration word complete without error and change nothing. Reads of it return bits 31:24 as 0.
- R7: With an installed size of at most 2048 KB, configuration bits 15:0 hold one low-order 1 per 128 KB board and the chip-density flag is 0.
- R8: With an installed size above 2048 KB, the board count is size/512 KB. The low-order mask of that many ones is ANDed with 0x5555, and the stored chip-density flag (bit 24) is 1; that flag still reads as 0 under R6.
- R9: An error strobe loads the syndrome into error bits 6:0 and the page into error bits 23:9. Without a strobe these fields hold.
- R10: A corrected report sets bit 29 only when control bit 28 is 1. An uncorrectable report sets bit 31.
- R11: When an error strobe and a software clear of the same flag happen in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | OFS_W | Word offset of the register |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_error | output | 1 | Non-existent offset |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| hw_err_strobe | input | 1 | One-cycle error report from the datapath |
| hw_err_uncorr | input | 1 | 1 = uncorrectable, 0 = corrected |
| hw_err_syndrome | input | 7 | Syndrome of the reported error |
| hw_err_page | input | 15 | Page of the reported error |

## Verification
The in-line assertions check the following on every cycle:
- the one-cycle response timing and the bad-offset error response;
- that error fields and flags move only on strobes or clears;
- that a hardware set wins over a clear;
- that the control and configuration words stay frozen without a write.

Only the bench scenarios can show the rest:
- the exact bit positions of the packed words;
- the masking of control writes;
- the reset-time board maps for both chip densities, observed on a small and a large instance;
- how the report-enable gate interacts with a sequence of reports.

// File: rtl/memctl_csr_pkg.sv
package memctl_csr_pkg;
    localparam int DATA_W = 32;
    localparam int SYN_W  = 7;
    localparam int PAGE_W = 15;
    localparam int MAP_W  = 16;

    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h1E00_007F;
    localparam logic [DATA_W-1:0] CFG_RD_MASK = 32'h00FF_FFFF;

    localparam int KB_PER_SMALL = 128;
    localparam int KB_PER_LARGE = 512;
    localparam int SMALL_LIMIT_KB = 2048;
    localparam logic [31:0] EVEN_SLOTS = 32'h0000_5555;

    typedef enum logic [1:0] {
        SEL_ERR  = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_CFG  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              sub;       // bit 31
        logic              sub_high;  // bit 30
        logic              corrected; // bit 29
        logic [PAGE_W-1:0] page;      // bits 23:9
        logic [SYN_W-1:0]  syndrome;  // bits 6:0
    } err_t;

    function automatic logic [DATA_W-1:0] pack_err(err_t e);
        logic [DATA_W-1:0] w;
        w = '0;
        w[31]   = e.sub;
        w[30]   = e.sub_high;
        w[29]   = e.corrected;
        w[23:9] = e.page;
        w[6:0]  = e.syndrome;
        return w;
    endfunction

    function automatic logic [MAP_W-1:0] present_map(int kb);
        int boards;
        logic [31:0] m;
        boards = (kb <= SMALL_LIMIT_KB) ? kb / KB_PER_SMALL : kb / KB_PER_LARGE;
        if (boards >= 32) m = '1;
        else              m = (32'd1 << boards) - 32'd1;
        if (kb > SMALL_LIMIT_KB) m = m & EVEN_SLOTS;
        return m[MAP_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] cfg_word(int kb);
        logic [DATA_W-1:0] w;
        w = '0;
        w[MAP_W-1:0] = present_map(kb);
        w[16]        = 1'b1;
        w[24]        = (kb > SMALL_LIMIT_KB);
        return w;
    endfunction
endpackage

// File: rtl/memctl_err_capture.sv
module memctl_err_capture
    import memctl_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_we,
    input  logic [2:0]        clr_bits,
    input  logic              crd_en,
    input  logic              hw_strobe,
    input  logic              hw_uncorr,
    input  logic [SYN_W-1:0]  hw_syndrome,
    input  logic [PAGE_W-1:0] hw_page,
    output logic [DATA_W-1:0] err_word
);
    err_t q, d;
    logic set_crd, set_sub;

    assign set_crd = hw_strobe && !hw_uncorr && crd_en;
    assign set_sub = hw_strobe && hw_uncorr;

    always_comb begin
        d = q;
        if (clr_we) begin
            if (clr_bits[0]) d.corrected = 1'b0;
            if (clr_bits[1]) d.sub_high  = 1'b0;
            if (clr_bits[2]) d.sub       = 1'b0;
        end
        if (hw_strobe) begin
            d.syndrome = hw_syndrome;
            d.page     = hw_page;
        end
        if (set_crd) d.corrected = 1'b1;
        if (set_sub) d.sub       = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign err_word = pack_err(q);

    assert_uncorr_sets_R10: assert property (@(posedge clk) disable iff (rst)
        hw_strobe && hw_uncorr |=> q.sub);
    assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (rst)
        set_crd && clr_we && clr_bits[0] |=> q.corrected);
    assert_crd_gated_R10: assert property (@(posedge clk) disable iff (rst)
        !q.corrected && !(hw_strobe && !hw_uncorr && crd_en) |=> !q.corrected);
    assert_fields_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !hw_strobe |=> $stable({q.syndrome, q.page}));
    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        clr_we && clr_bits[2] && !set_sub |=> !q.sub);
endmodule

// File: rtl/memctl_ctrl_reg.sv
module memctl_ctrl_reg
    import memctl_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              crd_en
);
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata & CTRL_MASK;
    end

    assign ctrl_word = q;
    assign crd_en    = q[28];

    assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));
endmodule

// File: rtl/memctl_cfg_reg.sv
module memctl_cfg_reg
    import memctl_csr_pkg::*;
#(
    parameter int INSTALLED_KB = 1536
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DATA_W-1:0] cfg_word_q
);
    localparam logic [DATA_W-1:0] RESET_WORD = cfg_word(INSTALLED_KB);

    always_ff @(posedge clk) begin
        if (rst) cfg_word_q <= RESET_WORD;
    end

    assert_cfg_const_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(cfg_word_q));
endmodule

// File: rtl/memctl_csr_file.sv
module memctl_csr_file
    import memctl_csr_pkg::*;
#(
    parameter int OFS_W        = 4,
    parameter int INSTALLED_KB = 1536
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [OFS_W-1:0]  acc_offset,
    input  logic [31:0]       acc_wdata,
    output logic              rsp_valid,
    output logic              rsp_error,
    output logic [31:0]       rsp_rdata,
    input  logic              hw_err_strobe,
    input  logic              hw_err_uncorr,
    input  logic [6:0]        hw_err_syndrome,
    input  logic [14:0]       hw_err_page
);
    reg_sel_e sel;
    logic [DATA_W-1:0] err_word, ctrl_word, cfg_word_q, rd_mux;
    logic crd_en, wr_err, wr_ctrl;

    always_comb begin
        unique case (acc_offset)
            OFS_W'(0): sel = SEL_ERR;
            OFS_W'(1): sel = SEL_CTRL;
            OFS_W'(2): sel = SEL_CFG;
            default:   sel = SEL_NONE;
        endcase
    end

    assign wr_err  = acc_valid && acc_write && (sel == SEL_ERR);
    assign wr_ctrl = acc_valid && acc_write && (sel == SEL_CTRL);

    memctl_err_capture u_err (
        .clk(clk), .rst(rst),
        .clr_we(wr_err), .clr_bits(acc_wdata[31:29]),
        .crd_en(crd_en),
        .hw_strobe(hw_err_strobe), .hw_uncorr(hw_err_uncorr),
        .hw_syndrome(hw_err_syndrome), .hw_page(hw_err_page),
        .err_word(err_word)
    );

    memctl_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .we(wr_ctrl), .wdata(acc_wdata),
        .ctrl_word(ctrl_word), .crd_en(crd_en)
    );

    memctl_cfg_reg #(.INSTALLED_KB(INSTALLED_KB)) u_cfg (
        .clk(clk), .rst(rst), .cfg_word_q(cfg_word_q)
    );

    always_comb begin
        case (sel)
            SEL_ERR:  rd_mux = err_word;
            SEL_CTRL: rd_mux = ctrl_word;
            SEL_CFG:  rd_mux = cfg_word_q & CFG_RD_MASK;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_error <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_error <= acc_valid && (sel == SEL_NONE);
            rsp_rdata <= (acc_valid && !acc_write) ? rd_mux : '0;
        end
    end

    assert_rsp_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid);
    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !rsp_valid && !rsp_error);
    assert_bad_offset_R1: assert property (@(posedge clk) disable iff (rst)
        acc_valid && (acc_offset > OFS_W'(2)) |=> rsp_error && (rsp_rdata == '0));
endmodule

// File: tb/memctl_csr_file_bench.sv
module memctl_csr_file_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0] acc_offset = '0;
    logic [31:0] acc_wdata = '0;
    logic hw_err_strobe = 1'b0, hw_err_uncorr = 1'b0;
    logic [6:0] hw_err_syndrome = '0;
    logic [14:0] hw_err_page = '0;
    logic rsp_valid, rsp_error, rsp_valid_b, rsp_error_b;
    logic [31:0] rsp_rdata, rsp_rdata_b;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    memctl_csr_file #(.OFS_W(4), .INSTALLED_KB(1536)) u_memctl_csr_file (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_offset(acc_offset), .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
        .hw_err_strobe(hw_err_strobe), .hw_err_uncorr(hw_err_uncorr),
        .hw_err_syndrome(hw_err_syndrome), .hw_err_page(hw_err_page));

    memctl_csr_file #(.OFS_W(4), .INSTALLED_KB(3072)) u_memctl_csr_file_big (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_offset(acc_offset), .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid_b), .rsp_error(rsp_error_b), .rsp_rdata(rsp_rdata_b),
        .hw_err_strobe(1'b0), .hw_err_uncorr(1'b0),
        .hw_err_syndrome(7'd0), .hw_err_page(15'd0));

    typedef struct packed {
        logic        wr;
        logic [3:0]  ofs;
        logic [31:0] wd;
        logic        err;
        logic [31:0] rd;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 4'd0, 32'h0,        1'b0, 32'h0000_0000}, // R3 error word clear
        '{1'b0, 4'd1, 32'h0,        1'b0, 32'h0000_0000}, // R3 control clear
        '{1'b0, 4'd2, 32'h0,        1'b0, 32'h0001_0FFF}, // R3 R7 12 boards
        '{1'b1, 4'd1, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000}, // R5 write all ones
        '{1'b0, 4'd1, 32'h0,        1'b0, 32'h1E00_007F}, // R5 masked
        '{1'b1, 4'd1, 32'h00FF_FE00, 1'b0, 32'h0000_0000}, // R5 page field
        '{1'b0, 4'd1, 32'h0,        1'b0, 32'h0000_0000}, // R5 page reads 0
        '{1'b1, 4'd2, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000}, // R6 write accepted
        '{1'b0, 4'd2, 32'h0,        1'b0, 32'h0001_0FFF}, // R6 unchanged
        '{1'b0, 4'd3, 32'h0,        1'b1, 32'h0000_0000}, // R1 bad read
        '{1'b1, 4'd15, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000}, // R1 bad write
        '{1'b0, 4'd1, 32'h0,        1'b0, 32'h0000_0000}, // R1 no side effect
        '{1'b1, 4'd0, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000}  // R4 clear idle word
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [3:0] ofs, input logic [31:0] wd,
                          output logic err, output logic [31:0] rd, output logic vld);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_offset = ofs; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        vld = rsp_valid; err = rsp_error; rd = rsp_rdata;
    endtask

    task automatic strobe(input logic unc, input logic [6:0] syn, input logic [14:0] pg);
        @(negedge clk);
        hw_err_strobe = 1'b1; hw_err_uncorr = unc; hw_err_syndrome = syn; hw_err_page = pg;
        @(negedge clk);
        hw_err_strobe = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [3:0] ofs, input logic [31:0] exp);
        logic e, v;
        logic [31:0] r;
        access(1'b0, ofs, 32'h0, e, r, v);
        check(tag, r, exp);
    endtask

    initial begin
        logic e, v;
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R3 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i].wr, VEC[i].ofs, VEC[i].wd, e, r, v);
            check($sformatf("R2 vec %0d valid", i), {31'b0, v}, 32'h1);
            check($sformatf("R1 vec %0d error", i), {31'b0, e}, {31'b0, VEC[i].err});
            check($sformatf("R5 R6 vec %0d rdata", i), r, VEC[i].rd);
        end
        read_chk("R4 word after clear", 4'd0, 32'h0);

        // R2: idle cycle gives no response
        @(negedge clk);
        check("R2 idle rsp_valid", {31'b0, rsp_valid}, 32'h0);

        // R8: large instance, 6 boards on even slots, bit 24 hidden
        access(1'b0, 4'd2, 32'h0, e, r, v);
        check("R8 large map", rsp_rdata_b, 32'h0001_0015);

        // R9 R10: corrected report with enable off
        strobe(1'b0, 7'h55, 15'h1234);
        read_chk("R9 R10 corrected gated", 4'd0, 32'h0024_6855);

        // R10: enable and report again
        access(1'b1, 4'd1, 32'h1000_0000, e, r, v);
        strobe(1'b0, 7'h0A, 15'h7FFF);
        read_chk("R10 corrected flag", 4'd0, 32'h20FF_FE0A);
        strobe(1'b1, 7'h7F, 15'h0001);
        read_chk("R10 R9 uncorrectable", 4'd0, 32'hA000_027F);

        // R4: selective clear
        access(1'b1, 4'd0, 32'h2000_0000, e, r, v);
        read_chk("R4 clear bit29", 4'd0, 32'h8000_027F);
        access(1'b1, 4'd0, 32'h5FFF_FFFF, e, r, v);
        read_chk("R4 other bits untouched", 4'd0, 32'h8000_027F);

        // R11: set and clear in the same cycle
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_offset = 4'd0; acc_wdata = 32'h8000_0000;
        hw_err_strobe = 1'b1; hw_err_uncorr = 1'b1; hw_err_syndrome = 7'h01; hw_err_page = 15'h0;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; hw_err_strobe = 1'b0;
        read_chk("R11 set wins", 4'd0, 32'h8000_0001);
        access(1'b1, 4'd0, 32'h8000_0000, e, r, v);
        read_chk("R4 later clear", 4'd0, 32'h0000_0001);

        // R3: second reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_chk("R3 error after reset", 4'd0, 32'h0);
        read_chk("R3 control after reset", 4'd1, 32'h0);
        read_chk("R3 R7 config after reset", 4'd2, 32'h0001_0FFF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule